// File: doc/BRIEF.md
# Programmable Rise/Fall Delay Element

This block delays a single-bit signal, typically the request wire of a bundled-data pipeline stage. The request must arrive no earlier than the data it travels with. A rising transition on the input reaches the output after one programmed number of clock cycles. A falling transition reaches the output after a second number of cycles, set on its own. Because both edges are delayed, a four-phase return-to-zero handshake passes through intact. The pulse width at the output may differ from the pulse width at the input.

The input is sampled on each rising clock edge and compared with the current output level. While the two differ, a counter runs against the setting for the direction of that edge. When the count reaches the setting, the output takes the input level. If the input returns to the output level before then, the count is dropped and the output never moves. A pulse shorter than the applicable delay is therefore filtered out.

Top module: `edge_dly_top`

## Requirements
- R1: The block has one signal input `din` and one signal output `dout`. While `rst_n` is low, `dout` is 0 and any count in progress is cleared. After `rst_n` rises, a pending input level is timed from zero.
- R2: A rising edge is timed as follows. Let edge k be the first clock edge at which `din`=1 is sampled while `dout`=0. If `din` stays 1 at edges k through k+`rise_dly`, then `dout` becomes 1 right after edge k+`rise_dly`.
- R3: A falling edge is timed the same way. Let edge k be the first clock edge at which `din`=0 is sampled while `dout`=1. If `din` stays 0 at edges k through k+`fall_dly`, then `dout` becomes 0 right after edge k+`fall_dly`.
- R4: A setting of 0 makes `dout` follow `din` right after the first edge that samples the new level.
- R5: `dout` changes only to the sampled `din` level. If `din` returns to the `dout` level before the count expires, `dout` does not change. The next transition is then timed from zero again.
- R6: For an input high pulse lasting H edges, with H greater than `rise_dly`, followed by a long enough low time, `dout` is high for exactly H + `fall_dly` - `rise_dly` cycles.
- R7: Each setting is an unsigned 6-bit cycle count. The largest value, 63, is honoured exactly.
- R8: A setting is read on every cycle of a wait. If it is lowered to or below the number of edges already counted, `dout` changes right after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Signal to be delayed, synchronous to clk |
| rise_dly | input | 6 | Cycles of delay applied to a rising edge |
| fall_dly | input | 6 | Cycles of delay applied to a falling edge |
| dout | output | 1 | Delayed signal |

## Verification
Two events can fall on the same clock edge. One is the count reaching its setting. The other is the input returning to the output level, or a setting change that lands on an already elapsed count. The bench sweeps the input pulse length across the boundary, one edge short of the setting, exactly at it and beyond it. It judges every cycle against an arithmetic expectation of when the output is high. Separate cases lower the rise setting in the middle of a wait, apply reset in the middle of a count, and send short glitches against a long fall delay.

// File: rtl/edge_dly_pkg.sv
package edge_dly_pkg;

  localparam int unsigned DLY_W_DEF = 6;

  // A wait ends once the edges already counted reach the setting.
  function automatic logic dly_expired(input int unsigned counted, input int unsigned setting);
    return counted >= setting;
  endfunction

endpackage

// File: rtl/edge_dly_sel.sv
module edge_dly_sel #(
  parameter int unsigned W = 6
) (
  input  logic         target_hi,
  input  logic [W-1:0] rise_set,
  input  logic [W-1:0] fall_set,
  output logic [W-1:0] limit
);
  always_comb begin
    if (target_hi) limit = rise_set;
    else           limit = fall_set;
  end
endmodule

// File: rtl/edge_dly_cnt.sv
module edge_dly_cnt #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pending,
  input  logic [W-1:0] limit,
  output logic         fire,
  output logic [W-1:0] count
);
  import edge_dly_pkg::*;

  assign fire = pending && dly_expired(int'(count), int'(limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (!pending || fire) count <= '0;
    else                       count <= count + 1'b1;
  end
endmodule

// File: rtl/edge_dly_top.sv
module edge_dly_top #(
  parameter int unsigned DLY_W = edge_dly_pkg::DLY_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [DLY_W-1:0] rise_dly,
  input  logic [DLY_W-1:0] fall_dly,
  output logic             dout
);
  logic             dout_q;
  logic             mismatch;
  logic             fire;
  logic             cancel;
  logic [DLY_W-1:0] limit;
  logic [DLY_W-1:0] cnt;

  assign mismatch = din ^ dout_q;
  assign cancel   = !mismatch && (cnt != '0);

  edge_dly_sel #(.W(DLY_W)) u_sel (
    .target_hi (din),
    .rise_set  (rise_dly),
    .fall_set  (fall_dly),
    .limit     (limit)
  );

  edge_dly_cnt #(.W(DLY_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .pending (mismatch),
    .limit   (limit),
    .fire    (fire),
    .count   (cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout_q <= 1'b0;
    else if (fire) dout_q <= din;
  end

  assign dout = dout_q;
endmodule

// File: rtl/edge_dly_chk.sv
module edge_dly_chk #(
  parameter int unsigned W = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         din,
  input logic [W-1:0] rise_dly,
  input logic [W-1:0] fall_dly,
  input logic         dout,
  input logic         mismatch,
  input logic         cancel,
  input logic [W-1:0] cnt
);
  logic       dout_d;
  logic [7:0] run;
  logic       fresh;
  logic [7:0] run_eff;

  // Independent view of the wait: consecutive differing edges since the output last moved.
  assign fresh   = dout != dout_d;
  assign run_eff = fresh ? 8'd0 : run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_d <= 1'b0;
      run    <= 8'd0;
    end else begin
      dout_d <= dout;
      if (din == dout)     run <= 8'd0;
      else if (run_eff != 8'hff) run <= run_eff + 8'd1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) p_reset_low_r1: assert (dout == 1'b0);
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (din == dout) |=> $stable(dout));

  p_cancel_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> (cnt == '0) || (din != dout));

  p_zero_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (din && !dout && rise_dly == '0) |=> dout);

  p_zero_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!din && dout && fall_dly == '0) |=> !dout);

  p_rise_expire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (din && !dout && run_eff >= 8'(rise_dly)) |=> dout);

  p_rise_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (din && !dout && run_eff < 8'(rise_dly)) |=> !dout);

  p_fall_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!din && dout && run_eff >= 8'(fall_dly)) |=> !dout);

  p_fall_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!din && dout && run_eff < 8'(fall_dly)) |=> dout);

  p_wait_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> (run_eff <= 8'd64));
endmodule

bind edge_dly_top edge_dly_chk #(.W(DLY_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .din      (din),
  .rise_dly (rise_dly),
  .fall_dly (fall_dly),
  .dout     (dout),
  .mismatch (mismatch),
  .cancel   (cancel),
  .cnt      (cnt)
);

// File: tb/edge_dly_top_bench.sv
`timescale 1ns/1ps
module edge_dly_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       din = 1'b0;
  logic [5:0] rise_dly = '0;
  logic [5:0] fall_dly = '0;
  logic       dout;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  edge_dly_top u_edge_dly_top (
    .clk(clk), .rst_n(rst_n), .din(din),
    .rise_dly(rise_dly), .fall_dly(fall_dly), .dout(dout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Expected output after pulse edge j: high pulse of h edges, settings r and f.
  function automatic bit pulse_exp(int j, int h, int r, int f);
    return (h >= r + 1) && (j >= r) && (j < h + f);
  endfunction

  task automatic run_pulse(input int h, input int r, input int f, input string req);
    int high_cycles = 0;
    rise_dly = 6'(r);
    fall_dly = 6'(f);
    for (int j = 0; j < h + f + 2; j++) begin
      din = (j < h);
      step();
      chk(dout == pulse_exp(j, h, r, f), req, int'(dout), int'(pulse_exp(j, h, r, f)));
      if (dout) high_cycles++;
    end
    // R6: output width is the input width shifted by the two settings
    if (h >= r + 1)
      chk(high_cycles == h + f - r, "R6", high_cycles, h + f - r);
    else
      chk(high_cycles == 0, "R5", high_cycles, 0);
  endtask

  initial begin
    #50000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      report();
      $finish;
    end
  end

  initial begin
    int vals[5] = '{0, 1, 2, 3, 6};
    @(negedge clk);
    chk(dout == 1'b0, "R1", int'(dout), 0);
    step();
    rst_n = 1'b1;
    step();
    chk(dout == 1'b0, "R1", int'(dout), 0);

    // Near-exhaustive sweep over small settings and pulse lengths around the boundary
    foreach (vals[a]) foreach (vals[b])
      for (int h = 1; h <= vals[a] + 3; h++)
        run_pulse(h, vals[a], vals[b], (vals[a] == 0 || vals[b] == 0) ? "R4" : (h <= vals[a] ? "R5" : "R2"));

    // Falling delays exercised on their own
    run_pulse(4, 1, 5, "R3");
    run_pulse(2, 0, 9, "R3");

    // R7: largest settings
    run_pulse(64, 63, 63, "R7");
    run_pulse(63, 63, 0, "R7");

    // Random settings and pulse lengths
    for (int t = 0; t < 20; t++) begin
      int r = int'($urandom % 64);
      int f = int'($urandom % 64);
      int h = int'($urandom % 70) + 1;
      run_pulse(h, r, f, "R2");
    end

    // R5: short low glitches against a long fall delay leave the output high
    rise_dly = 6'd0; fall_dly = 6'd4;
    din = 1'b1; step();
    chk(dout == 1'b1, "R4", int'(dout), 1);
    for (int g = 1; g <= 4; g++) begin
      din = 1'b0;
      for (int k = 0; k < g; k++) begin
        step();
        chk(dout == 1'b1, "R5", int'(dout), 1);
      end
      din = 1'b1;
      step();
      chk(dout == 1'b1, "R5", int'(dout), 1);
    end
    din = 1'b0;
    for (int j = 0; j < 7; j++) begin
      step();
      chk(dout == (j < 4), "R3", int'(dout), int'(j < 4));
    end

    // R8: lowering the rise setting below the elapsed count fires on the next edge
    rise_dly = 6'd20; fall_dly = 6'd0;
    din = 1'b1;
    for (int j = 0; j < 10; j++) begin
      step();
      chk(dout == 1'b0, "R8", int'(dout), 0);
    end
    rise_dly = 6'd3;
    step();
    chk(dout == 1'b1, "R8", int'(dout), 1);
    din = 1'b0; step();
    chk(dout == 1'b0, "R4", int'(dout), 0);

    // R1: reset in the middle of a count restarts timing from zero
    rise_dly = 6'd10;
    din = 1'b1;
    for (int j = 0; j < 3; j++) step();
    rst_n = 1'b0;
    step();
    chk(dout == 1'b0, "R1", int'(dout), 0);
    step();
    rst_n = 1'b1;
    for (int j = 0; j < 14; j++) begin
      step();
      chk(dout == (j >= 10), "R1", int'(dout), int'(j >= 10));
    end
    din = 1'b0; step();
    chk(dout == 1'b0, "R4", int'(dout), 0);

    done = 1;
    report();
    $finish;
  end
endmodule